// File: doc/BRIEF.md
# Deficit-Driven Head Cache Scheduler

This block keeps the front bytes of several logical FIFOs in a small on-chip cache, while the bodies of those FIFOs sit in a slow bulk memory. The bulk memory can only move whole blocks of `BLK` bytes. Each queue has a circular cache slot of `CAP` bytes. An arbiter may ask for one byte per cycle from any queue, in any order. The block answers each request with the byte at the head of that queue. Every cycle counts as one timeslot.

Once every `BLK` cycles, the block picks one queue to top up. It chooses the queue whose free space in the cache (its deficit, `CAP` minus occupancy) is largest. Only queues that the bulk memory reports as holding at least one full block can be chosen. The block issues a refill request for the chosen queue. Bulk memory answers on the refill data port with one block for that queue, and the block appends that block to the queue's cache slot. If `CAP` is large enough for the number of queues and the block size, every byte the arbiter asks for is already in the cache.

Control and datapath are separate modules. The control module holds the period counter, the occupancy counters, the largest-deficit selection and the error flags. The datapath holds the per-queue circular storage and the head and tail pointers.

Top module: `head_cache_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, `rdDataValid`, `refReqValid`, `underflowErr` and `overflowErr` are all low. Reset also empties every queue.
- R2: `refReqValid` is high for exactly one cycle in every window of `BLK` cycles. It is high in cycle k·`BLK` after reset is released (k ≥ 1), and only when at least one queue is eligible. It is never high in any other cycle.
- R3: `refReqQid` names the eligible queue with the largest deficit. The deficit is `CAP` minus occupancy, taken in the cycle before `refReqValid` rises.
- R4: When several eligible queues share the largest deficit, the queue with the lowest index is chosen.
- R5: A queue whose `bulkAvail` bit is low is never chosen. If every bit of `bulkAvail` is low in the deciding cycle, that refill slot is skipped and no request is issued.
- R6: A read of a non-empty queue makes `rdDataValid` high in the next cycle, with `rdData` holding that queue's oldest byte. Bytes come out in first-in, first-out order.
- R7: A refill that is accepted appends `BLK` bytes to its queue. Byte i of the block sits in `refData[8i+7:8i]`, and byte 0 is the first of the block to be read.
- R8: If a read and a refill target the same queue in the same cycle, both take effect. Occupancy becomes X+`BLK`−1 and no byte is lost or reordered.
- R9: A read of a queue with zero occupancy returns no data (`rdDataValid` stays low) and sets `underflowErr`. The flag stays high until reset.
- R10: A refill that would raise occupancy above `CAP` (after any read in the same cycle) is discarded and sets `overflowErr`. The flag stays high until reset, and occupancy never exceeds `CAP`.
- R11: Head and tail pointers wrap modulo `CAP`, so first-in, first-out order holds across many times `CAP` bytes per queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one timeslot |
| rst | input | 1 | Synchronous active-high reset |
| rdValid | input | 1 | Arbiter read request valid |
| rdQid | input | QW | Queue to read one byte from |
| rdData | output | 8 | Byte returned for the previous cycle's read |
| rdDataValid | output | 1 | `rdData` holds a valid byte |
| bulkAvail | input | NQ | Per queue: bulk memory holds at least one block |
| refReqValid | output | 1 | Refill request to bulk memory |
| refReqQid | output | QW | Queue the refill is requested for |
| refValid | input | 1 | A refill block is present |
| refQid | input | QW | Queue the refill block belongs to |
| refData | input | 8·BLK | Refill block, byte 0 in the low bits |
| underflowErr | output | 1 | Sticky: a read hit an empty queue |
| overflowErr | output | 1 | Sticky: a refill would have exceeded capacity |

## Verification
The bench checks the block with several input patterns. Letting every queue fill from empty with no reads shows whether ties in the selection go to the lowest index. Masking `bulkAvail` shows that blocked queues are passed over, and that a slot is skipped when no queue is eligible. A long run of random reads to non-empty queues tells largest-deficit selection apart from simpler orders such as round-robin. The same run wraps every pointer many times over. A phase that always reads the queue being refilled exercises the simultaneous update. A final phase reads an empty queue and refills one queue without draining it, which separates the two error paths.

// File: rtl/hc_pkg.sv
package hc_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic rdDo;   // read accepted this cycle
    logic wrDo;   // refill accepted this cycle
  } hcStrobe_t;
endpackage

// File: rtl/hc_ctrl.sv
module hc_ctrl #(
  parameter int NQ  = 5,
  parameter int BLK = 6,
  parameter int CAP = 24,
  localparam int QW = $clog2(NQ),
  localparam int OW = $clog2(CAP + BLK + 1),
  localparam int SW = (BLK > 1) ? $clog2(BLK) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rdValid,
  input  logic [QW-1:0]    rdQid,
  input  logic [NQ-1:0]    bulkAvail,
  input  logic             refValid,
  input  logic [QW-1:0]    refQid,
  output hc_pkg::hcStrobe_t strobe,
  output logic             refReqValid,
  output logic [QW-1:0]    refReqQid,
  output logic             underflowErr,
  output logic             overflowErr
);
  localparam logic [OW-1:0] CAP_V = OW'(CAP);
  localparam logic [OW-1:0] BLK_V = OW'(BLK);
  localparam logic [SW-1:0] LAST_SLOT = SW'(BLK - 1);

  logic [OW-1:0] occ [NQ];
  logic [SW-1:0] slotCnt;
  logic          rdInRange, refInRange;
  logic          rdOk, refOk;
  logic [OW-1:0] refNewOcc;
  logic          anyElig;
  logic [QW-1:0] bestQ;
  logic [OW-1:0] bestDef;

  assign rdInRange  = rdQid < QW'(NQ);
  assign refInRange = refQid < QW'(NQ);
  assign rdOk       = rdValid && rdInRange && (occ[rdQid] != '0);
  assign refNewOcc  = occ[refQid] + BLK_V - OW'(rdOk && (rdQid == refQid));
  assign refOk      = refValid && refInRange && (refNewOcc <= CAP_V);

  assign strobe.rdDo = rdOk;
  assign strobe.wrDo = refOk;

  // largest deficit among eligible queues, lowest index on ties
  always_comb begin
    anyElig = 1'b0;
    bestQ   = '0;
    bestDef = '0;
    for (int q = 0; q < NQ; q++) begin
      if (bulkAvail[q] && (!anyElig || (CAP_V - occ[q]) > bestDef)) begin
        anyElig = 1'b1;
        bestQ   = QW'(q);
        bestDef = CAP_V - occ[q];
      end
    end
  end

  generate
    for (genvar g = 0; g < NQ; g++) begin : g_occ
      logic decHere, incHere;
      assign decHere = rdOk && (rdQid == QW'(g));
      assign incHere = refOk && (refQid == QW'(g));
      always_ff @(posedge clk) begin
        if (rst) occ[g] <= '0;
        else     occ[g] <= occ[g] - OW'(decHere) + (incHere ? BLK_V : '0);
      end
      p_occ_cap_r10: assert property (@(posedge clk) disable iff (rst)
        occ[g] <= CAP_V);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      slotCnt      <= '0;
      refReqValid  <= 1'b0;
      refReqQid    <= '0;
      underflowErr <= 1'b0;
      overflowErr  <= 1'b0;
    end else begin
      slotCnt      <= (slotCnt == LAST_SLOT) ? '0 : slotCnt + 1'b1;
      refReqValid  <= (slotCnt == LAST_SLOT) && anyElig;
      if ((slotCnt == LAST_SLOT) && anyElig) refReqQid <= bestQ;
      if (rdValid && !rdOk) underflowErr <= 1'b1;
      if (refValid && !refOk) overflowErr <= 1'b1;
    end
  end

  // R2: a request appears only in the cycle after the period's last slot
  p_req_slot_r2: assert property (@(posedge clk) disable iff (rst)
    refReqValid |-> (slotCnt == '0));
  p_req_issue_r2: assert property (@(posedge clk) disable iff (rst)
    ((slotCnt == LAST_SLOT) && (bulkAvail != '0)) |=> refReqValid);
  p_skip_r5: assert property (@(posedge clk) disable iff (rst)
    ((slotCnt == LAST_SLOT) && (bulkAvail == '0)) |=> !refReqValid);
  p_uf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    underflowErr |=> underflowErr);
  p_of_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    overflowErr |=> overflowErr);
endmodule

// File: rtl/hc_datapath.sv
module hc_datapath #(
  parameter int NQ  = 5,
  parameter int BLK = 6,
  parameter int CAP = 24,
  localparam int QW = $clog2(NQ),
  localparam int PW = $clog2(CAP),
  localparam int XW = PW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  hc_pkg::hcStrobe_t strobe,
  input  logic [QW-1:0]     rdQid,
  input  logic [QW-1:0]     refQid,
  input  logic [8*BLK-1:0]  refData,
  output logic [7:0]        rdData,
  output logic              rdDataValid
);
  localparam logic [XW-1:0] CAP_X = XW'(CAP);

  logic [7:0]    mem  [NQ][CAP];
  logic [PW-1:0] head [NQ];
  logic [PW-1:0] tail [NQ];

  function automatic logic [PW-1:0] wrapAdd(input logic [PW-1:0] base, input int unsigned step);
    logic [XW-1:0] s;
    s = XW'(base) + XW'(step);
    if (s >= CAP_X) s = s - CAP_X;
    return s[PW-1:0];
  endfunction

  generate
    for (genvar g = 0; g < NQ; g++) begin : g_q
      logic rdHere, wrHere;
      assign rdHere = strobe.rdDo && (rdQid == QW'(g));
      assign wrHere = strobe.wrDo && (refQid == QW'(g));
      always_ff @(posedge clk) begin
        if (rst) begin
          head[g] <= '0;
          tail[g] <= '0;
        end else begin
          if (rdHere) head[g] <= wrapAdd(head[g], 1);
          if (wrHere) tail[g] <= wrapAdd(tail[g], BLK);
        end
      end
      always_ff @(posedge clk) begin
        if (wrHere) begin
          for (int i = 0; i < BLK; i++) begin
            mem[g][wrapAdd(tail[g], i)] <= refData[8*i +: 8];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdDataValid <= 1'b0;
      rdData      <= '0;
    end else begin
      rdDataValid <= strobe.rdDo;
      if (strobe.rdDo) rdData <= mem[rdQid][head[rdQid]];
    end
  end

  p_rd_valid_r6: assert property (@(posedge clk) disable iff (rst)
    rdDataValid |-> $past(strobe.rdDo));
endmodule

// File: rtl/head_cache_top.sv
module head_cache_top #(
  parameter int NQ  = 5,
  parameter int BLK = 6,
  parameter int CAP = 24,
  localparam int QW = $clog2(NQ)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rdValid,
  input  logic [QW-1:0]    rdQid,
  output logic [7:0]       rdData,
  output logic             rdDataValid,
  input  logic [NQ-1:0]    bulkAvail,
  output logic             refReqValid,
  output logic [QW-1:0]    refReqQid,
  input  logic             refValid,
  input  logic [QW-1:0]    refQid,
  input  logic [8*BLK-1:0] refData,
  output logic             underflowErr,
  output logic             overflowErr
);
  hc_pkg::hcStrobe_t strobe;

  hc_ctrl #(.NQ(NQ), .BLK(BLK), .CAP(CAP)) u_ctrl (
    .clk(clk), .rst(rst), .rdValid(rdValid), .rdQid(rdQid),
    .bulkAvail(bulkAvail), .refValid(refValid), .refQid(refQid),
    .strobe(strobe), .refReqValid(refReqValid), .refReqQid(refReqQid),
    .underflowErr(underflowErr), .overflowErr(overflowErr)
  );

  hc_datapath #(.NQ(NQ), .BLK(BLK), .CAP(CAP)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .rdQid(rdQid),
    .refQid(refQid), .refData(refData),
    .rdData(rdData), .rdDataValid(rdDataValid)
  );

  // R1: first cycle after reset is quiet
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $fell(rst) |-> (!rdDataValid && !refReqValid && !underflowErr && !overflowErr));
endmodule

// File: tb/sim_head_cache_top.sv
module sim_head_cache_top;
  localparam int NQ = 5, BLK = 6, CAP = 24, QW = $clog2(NQ);

  logic clk = 1'b0, rst = 1'b1;
  logic rdValid = 1'b0; logic [QW-1:0] rdQid = '0;
  logic [NQ-1:0] bulkAvail = '0;
  logic refValid = 1'b0; logic [QW-1:0] refQid = '0;
  logic [8*BLK-1:0] refData = '0;
  logic [7:0] rdData; logic rdDataValid, refReqValid, underflowErr, overflowErr;
  logic [QW-1:0] refReqQid;

  always #4 clk = ~clk;

  head_cache_top #(.NQ(NQ), .BLK(BLK), .CAP(CAP)) u0 (.*);

  typedef struct {
    bit rdV; logic [7:0] rdD; bit reqV; int reqQ; bit uf; bit of; string tag;
  } exp_t;
  exp_t expQ[$];

  int checks = 0, failures = 0;
  int mOcc [NQ];
  logic [7:0] mBytes [NQ][$];
  int mSeq [NQ];
  int mCnt; bit mUf, mOf; bit pendV; int pendQ;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // monitor: compares each cycle's outputs against the scoreboard
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      chk(rdDataValid == e.rdV, e.tag, "rdDataValid", int'(rdDataValid), int'(e.rdV));
      if (e.rdV) chk(rdData == e.rdD, e.tag, "rdData", int'(rdData), int'(e.rdD));
      chk(refReqValid == e.reqV, e.tag, "refReqValid", int'(refReqValid), int'(e.reqV));
      if (e.reqV) chk(int'(refReqQid) == e.reqQ, e.tag, "refReqQid", int'(refReqQid), e.reqQ);
      chk(underflowErr == e.uf, e.tag, "underflowErr", int'(underflowErr), int'(e.uf));
      chk(overflowErr == e.of, e.tag, "overflowErr", int'(overflowErr), int'(e.of));
    end
  end

  task automatic modelReset();
    for (int q = 0; q < NQ; q++) begin mOcc[q] = 0; mBytes[q].delete(); mSeq[q] = 0; end
    mCnt = 0; mUf = 0; mOf = 0; pendV = 0; pendQ = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; rdValid = 0; refValid = 0;
    repeat (3) @(negedge clk);
    chk(!rdDataValid && !refReqValid && !underflowErr && !overflowErr, "R1", "outputs in reset",
        int'({rdDataValid, refReqValid, underflowErr, overflowErr}), 0);
    rst = 1'b0;
    modelReset();
  endtask

  // driver: one timeslot; called at a negedge, drives inputs and pushes the expectation
  task automatic step(input bit rv, input int rq, input logic [NQ-1:0] avail, input string tag);
    exp_t e;
    bit rdOk; int newOcc; int best; int bestDef;
    rdValid = rv; rdQid = QW'(rq); bulkAvail = avail;
    refValid = pendV; refQid = QW'(pendQ);
    for (int i = 0; i < BLK; i++) refData[8*i +: 8] = 8'((pendQ * 40 + mSeq[pendQ] + i) & 255);
    e.tag = tag; e.rdD = '0;
    // decision uses occupancy before this edge (R3, R4, R5)
    best = -1; bestDef = -1;
    if (mCnt == BLK - 1)
      for (int q = 0; q < NQ; q++)
        if (avail[q] && (CAP - mOcc[q]) > bestDef) begin best = q; bestDef = CAP - mOcc[q]; end
    e.reqV = (best >= 0); e.reqQ = best;
    // read (R6, R9)
    rdOk = rv && mOcc[rq] > 0;
    e.rdV = rdOk;
    if (rdOk) begin e.rdD = mBytes[rq].pop_front(); mOcc[rq]--; end
    else if (rv) mUf = 1;
    // refill (R7, R8, R10)
    if (pendV) begin
      newOcc = mOcc[pendQ] + BLK;
      if (newOcc <= CAP) begin
        for (int i = 0; i < BLK; i++) mBytes[pendQ].push_back(8'((pendQ * 40 + mSeq[pendQ] + i) & 255));
        mOcc[pendQ] = newOcc;
      end else mOf = 1;
      mSeq[pendQ] += BLK;
    end
    e.uf = mUf; e.of = mOf;
    expQ.push_back(e);
    mCnt = (mCnt + 1) % BLK;
    pendV = e.reqV; pendQ = (best >= 0) ? best : 0;
    @(negedge clk);
  endtask

  function automatic int pickNonEmpty(input int seed);
    for (int k = 0; k < NQ; k++) if (mOcc[(seed + k) % NQ] > 0) return (seed + k) % NQ;
    return -1;
  endfunction

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int r;
    doReset();
    // R4: all queues start tied; refills go to 0,1,2,3,4 in turn
    for (int c = 0; c < 5 * BLK + 1; c++) step(0, 0, '1, "R4");
    // R5: queues 0,1 blocked, then none eligible (slot skipped)
    for (int c = 0; c < 2 * BLK; c++) step(0, 0, 5'b11100, "R5");
    for (int c = 0; c < 2 * BLK; c++) step(0, 0, 5'b00000, "R5");
    // R3/R6/R7/R11: random reads to non-empty queues
    for (int c = 0; c < 3000; c++) begin
      r = pickNonEmpty($urandom_range(0, NQ - 1));
      if (r >= 0 && $urandom_range(0, 19) != 0) step(1, r, '1, "R3");
      else step(0, 0, '1, "R11");
    end
    // R8: read the queue being refilled in the same cycle
    for (int c = 0; c < 40 * BLK; c++) begin
      if (pendV && mOcc[pendQ] > 0) step(1, pendQ, '1, "R8");
      else begin
        r = pickNonEmpty(c % NQ);
        step(r >= 0, (r >= 0) ? r : 0, '1, "R8");
      end
    end
    // drain queue 0 under no refills, then read it empty (R9)
    while (mOcc[0] > 0) step(1, 0, '0, "R6");
    step(1, 0, '0, "R9");
    for (int c = 0; c < BLK; c++) step(0, 0, '0, "R9");
    // R10: only queue 0 refilled, never read, until it overflows
    for (int c = 0; c < 8 * BLK; c++) step(0, 0, 5'b00001, "R10");
    chk(mOf == 1, "R10", "model reached overflow", int'(mOf), 1);
    // reset clears sticky flags (R1)
    doReset();
    step(0, 0, '0, "R1");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule